// File: doc/BRIEF.md
# Serial memory status register and write guard

This block holds the 8-bit status register of a serial non-volatile memory and decides, every cycle, whether a status update or an array write may go ahead. The serial front end presents decoded events to it: write-enable and write-disable commands, a status write carrying a data byte, the start of an array write with its target address, and the end of the self-timed programming cycle. The block answers with the readable status byte and two permission flags. The lock bit and the two block-protect bits stand in for non-volatile cells. They are ordinary flops that reset to zero.

A three-state cycle machine tracks the programming cycle. Its states are `CYC_IDLE`, `CYC_ARRAY` and `CYC_STATUS`. It has four transitions:

- **start_status** goes from `CYC_IDLE` to `CYC_STATUS`. It fires on an accepted status write.
- **start_array** goes from `CYC_IDLE` to `CYC_ARRAY`. It fires on an allowed array start when no status write is accepted in the same cycle.
- **finish_array** goes from `CYC_ARRAY` to `CYC_IDLE`. It fires on `cyc_done`.
- **finish_status** goes from `CYC_STATUS` to `CYC_IDLE`. It fires on `cyc_done` and commits the pending protect values.

`cyc_done` in `CYC_IDLE` leaves the machine where it is.

The hardware lock combines the lock bit with the active-low protect pin. While the lock is active the status register is read-only. Block protection compares the top two address bits against the protect code.

Top module: `nvm_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, and neither permission flag is raised.
- R2: The status byte layout is as follows:
  - bit 7 is the lock bit.
  - bits 6:4 always read 0.
  - bits 3:2 are the protect code.
  - bit 1 is the enable latch.
  - bit 0 is the busy flag.
- R3: `wen_set` sets bit 1 on the next clock and `wen_clr` clears it. When both are high in the same cycle, the latch is cleared.
- R4: `sr_accept` is high only in a cycle with `sr_wr` high, the enable latch set, the busy flag clear and the hardware lock inactive.
- R5: The hardware lock is active whenever bit 7 is 1 and `wprot_n` is 0, whichever of the two came first.
  - While the lock is active, status writes are rejected even if the enable latch is set.
  - Driving `wprot_n` high releases the lock.
- R6: An accepted status write sets bit 0 on the next clock. Bits 7 and 3:2 keep their old values for the whole cycle. The new values appear, together with bit 0 cleared, one clock after `cyc_done`.
- R7: A status write updates only bits 7 and 3:2 from `sr_din`. `sr_din` bits 6:4 and 1:0 have no effect on the status byte.
- R8: `arr_allow` equals: enable latch set, busy clear, and `arr_addr` outside the protected range. With a 15-bit address the protected ranges are:
  - code 00: nothing.
  - code 01: 6000h–7FFFh.
  - code 10: 4000h–7FFFh.
  - code 11: the whole array.
- R9: An array start is handled as follows:
  - With `arr_allow` high, `arr_start` sets bit 0 on the next clock. `cyc_done` then clears bits 0 and 1.
  - With `arr_allow` low, the start is ignored and the status byte does not change.
  - The address checked is the one presented with `arr_start`.
- R10: While bit 0 is 1, `sr_accept` and `arr_allow` stay low.
- R11: If an accepted status write and an array start arrive in the same idle cycle, the status write is the one performed.
- R12: `cyc_done` while idle changes nothing in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wprot_n | input | 1 | Write-protect pin; low protects |
| wen_set | input | 1 | Write-enable command decoded |
| wen_clr | input | 1 | Write-disable command decoded |
| sr_wr | input | 1 | Status write request at end of command |
| sr_din | input | 8 | Data byte of the status write |
| arr_start | input | 1 | Array write cycle start request |
| arr_addr | input | ADDR_W | Start address of the array write |
| cyc_done | input | 1 | Self-timed cycle finished |
| sr_dout | output | 8 | Readable status byte |
| sr_accept | output | 1 | Status write accepted this cycle |
| arr_allow | output | 1 | Array write allowed for arr_addr |

## Verification
The following internal faults show at the ports as described:

- **Enable latch held wrong.** It appears at bit 1 of `sr_dout` one clock after the offending command. In the same cycle it also appears as a wrong `sr_accept` or `arr_allow`.
- **Cycle machine in the wrong state.** It shows as a wrong busy bit one clock after a start or a `cyc_done`.
- **Pending protect values committed too early.** They show at bits 7 and 3:2 while bit 0 is still 1.
- **Range comparator decoding the wrong bits.** It gives a wrong `arr_allow` in the very cycle the address is presented.

// File: rtl/nvm_status_pkg.sv
package nvm_status_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ARRAY  = 2'd1,
        CYC_STATUS = 2'd2
    } cyc_state_t;

    localparam int SR_W    = 8;
    localparam int SR_LOCK = 7;
    localparam int SR_BPH  = 3;
    localparam int SR_BPL  = 2;
    localparam int SR_WEL  = 1;
    localparam int SR_BUSY = 0;
    localparam int BP_W    = SR_BPH - SR_BPL + 1;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
    } prot_cfg_t;

endpackage

// File: rtl/nvm_cyc_fsm.sv
module nvm_cyc_fsm
    import nvm_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_go,
    input  logic arr_go,
    input  logic cyc_done,
    output logic busy,
    output logic stat_commit,
    output logic cyc_end
);

    cyc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: begin
                if (stat_go)     state_d = CYC_STATUS;
                else if (arr_go) state_d = CYC_ARRAY;
            end
            CYC_ARRAY:  if (cyc_done) state_d = CYC_IDLE;
            CYC_STATUS: if (cyc_done) state_d = CYC_IDLE;
            default:    state_d = CYC_IDLE;
        endcase
    end

    always_comb begin
        busy        = 1'b0;
        stat_commit = 1'b0;
        cyc_end     = 1'b0;
        unique case (state_q)
            CYC_IDLE: ;
            CYC_ARRAY: begin
                busy    = 1'b1;
                cyc_end = cyc_done;
            end
            CYC_STATUS: begin
                busy        = 1'b1;
                cyc_end     = cyc_done;
                stat_commit = cyc_done;
            end
            default: busy = 1'b1;
        endcase
    end

    assert_status_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_IDLE && stat_go) |=> (state_q == CYC_STATUS));

    assert_idle_done_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_IDLE && cyc_done && !stat_go && !arr_go) |=> (state_q == CYC_IDLE));

endmodule

// File: rtl/nvm_blk_range.sv
module nvm_blk_range
    import nvm_status_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int TOP = ADDR_W - 1;

    logic [1:0] a_top;
    logic       unused_low;

    assign a_top      = addr[TOP -: 2];
    assign unused_low = ^addr[ADDR_W-3:0];

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (a_top == 2'b11);
            2'b10:   hit = a_top[1];
            default: hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/nvm_status_ctrl.sv
module nvm_status_ctrl
    import nvm_status_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wprot_n,
    input  logic              wen_set,
    input  logic              wen_clr,
    input  logic              sr_wr,
    input  logic [SR_W-1:0]   sr_din,
    input  logic              arr_start,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              cyc_done,
    output logic [SR_W-1:0]   sr_dout,
    output logic              sr_accept,
    output logic              arr_allow
);

    prot_cfg_t cfg_q, pend_q;
    logic      wel_q;
    logic      busy, stat_commit, cyc_end;
    logic      hw_lock, blk_hit, arr_go;
    logic      unused_din;

    assign unused_din = ^{sr_din[6:4], sr_din[1:0]};
    assign hw_lock    = cfg_q.lock & ~wprot_n;
    assign sr_accept  = sr_wr & wel_q & ~busy & ~hw_lock;
    assign arr_allow  = wel_q & ~busy & ~blk_hit;
    assign arr_go     = arr_start & arr_allow;

    nvm_blk_range #(.ADDR_W(ADDR_W)) u_range (
        .bp   (cfg_q.bp),
        .addr (arr_addr),
        .hit  (blk_hit)
    );

    nvm_cyc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_go     (sr_accept),
        .arr_go      (arr_go),
        .cyc_done    (cyc_done),
        .busy        (busy),
        .stat_commit (stat_commit),
        .cyc_end     (cyc_end)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wel_q <= 1'b0;
        else if (wen_clr || cyc_end) wel_q <= 1'b0;
        else if (wen_set)           wel_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (sr_accept) begin
            pend_q.lock <= sr_din[SR_LOCK];
            pend_q.bp   <= sr_din[SR_BPH:SR_BPL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cfg_q <= '0;
        else if (stat_commit) cfg_q <= pend_q;
    end

    always_comb begin
        sr_dout                 = '0;
        sr_dout[SR_LOCK]        = cfg_q.lock;
        sr_dout[SR_BPH:SR_BPL]  = cfg_q.bp;
        sr_dout[SR_WEL]         = wel_q;
        sr_dout[SR_BUSY]        = busy;
    end

    assert_wel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clr |=> !sr_dout[SR_WEL]);

    assert_accept_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_accept |-> (wel_q && !busy));

    assert_lock_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lock && !wprot_n) |-> !sr_accept);

    assert_prot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_done) |=> $stable(cfg_q));

    assert_end_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cyc_done) |=> (!wel_q && !busy));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sr_accept && !arr_allow));

endmodule

// File: tb/sim_nvm_status_ctrl.sv
module sim_nvm_status_ctrl;

    localparam int AW = 15;
    localparam int NV = 10;
    // entry: {protect code[1:0], address[14:0], expected arr_allow}
    localparam logic [17:0] VEC [NV] = '{
        {2'b00, 15'h7FFF, 1'b1},
        {2'b01, 15'h5FFF, 1'b1},
        {2'b01, 15'h6000, 1'b0},
        {2'b01, 15'h7FFF, 1'b0},
        {2'b10, 15'h3FFF, 1'b1},
        {2'b10, 15'h4000, 1'b0},
        {2'b11, 15'h0000, 1'b0},
        {2'b11, 15'h1234, 1'b0},
        {2'b00, 15'h0000, 1'b1},
        {2'b01, 15'h0000, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wprot_n = 1'b1;
    logic          wen_set = 1'b0, wen_clr = 1'b0, sr_wr = 1'b0;
    logic [7:0]    sr_din = '0;
    logic          arr_start = 1'b0, cyc_done = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [7:0]    sr_dout;
    logic          sr_accept, arr_allow;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nvm_status_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wprot_n(wprot_n),
        .wen_set(wen_set), .wen_clr(wen_clr),
        .sr_wr(sr_wr), .sr_din(sr_din),
        .arr_start(arr_start), .arr_addr(arr_addr),
        .cyc_done(cyc_done),
        .sr_dout(sr_dout), .sr_accept(sr_accept), .arr_allow(arr_allow)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic write_sr(logic [7:0] d);
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        sr_wr = 1'b1; sr_din = d; tick(); sr_wr = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        sr_wr = 1'b1; sr_din = 8'hFF; #1;
        chk8("R1 reset status", sr_dout, 8'h00);
        chk1("R1 reset accept", sr_accept, 1'b0);
        chk1("R1 reset allow", arr_allow, 1'b0);
        sr_wr = 1'b0;
        rst_n = 1'b1;
        tick();

        // table: block protection ranges (R8)
        for (int i = 0; i < NV; i++) begin
            write_sr({4'b0000, VEC[i][17:16], 2'b00});
            chk8("R8 protect code stored", sr_dout, {4'b0000, VEC[i][17:16], 2'b00});
            wen_set = 1'b1; tick(); wen_set = 1'b0;
            arr_addr = VEC[i][15:1]; #1;
            chk1("R8 range decision", arr_allow, VEC[i][0]);
            wen_clr = 1'b1; tick(); wen_clr = 1'b0;
        end
        write_sr(8'h00);

        // R3 enable latch
        wen_set = 1'b1; tick(); chk8("R3 set", sr_dout, 8'h02);
        wen_set = 1'b0; wen_clr = 1'b1; tick(); chk8("R3 clear", sr_dout, 8'h00);
        wen_set = 1'b1; tick(); chk8("R3 clear wins", sr_dout, 8'h00);
        wen_set = 1'b0; wen_clr = 1'b0;

        // R4 no latch, no accept
        sr_wr = 1'b1; sr_din = 8'hFF; #1;
        chk1("R4 accept without latch", sr_accept, 1'b0);
        tick(); sr_wr = 1'b0;
        chk8("R4 status untouched", sr_dout, 8'h00);

        // R6 / R7 / R10 status cycle
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        sr_wr = 1'b1; sr_din = 8'hFF; #1;
        chk1("R4 accept", sr_accept, 1'b1);
        tick(); sr_wr = 1'b0;
        chk8("R6 old values during cycle", sr_dout, 8'h03);
        sr_wr = 1'b1; sr_din = 8'h00; arr_addr = '0; #1;
        chk1("R10 accept while busy", sr_accept, 1'b0);
        chk1("R10 allow while busy", arr_allow, 1'b0);
        tick(); sr_wr = 1'b0;
        chk8("R6 frozen", sr_dout, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R7 only bits 7,3,2 written", sr_dout, 8'h8C);

        // R5 hardware lock, lock bit first
        wprot_n = 1'b0;
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        chk8("R2 layout", sr_dout, 8'h8E);
        sr_wr = 1'b1; sr_din = 8'h00; #1;
        chk1("R5 locked reject", sr_accept, 1'b0);
        tick(); sr_wr = 1'b0;
        chk8("R5 no cycle", sr_dout, 8'h8E);
        wprot_n = 1'b1;
        sr_wr = 1'b1; sr_din = 8'h00; #1;
        chk1("R5 pin high releases", sr_accept, 1'b1);
        tick(); sr_wr = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R5 unlocked write done", sr_dout, 8'h00);

        // R5 pin low first
        wprot_n = 1'b0;
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        sr_wr = 1'b1; sr_din = 8'h80; #1;
        chk1("R5 pin low lock clear", sr_accept, 1'b1);
        tick(); sr_wr = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R5 lock set", sr_dout, 8'h80);
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        sr_wr = 1'b1; sr_din = 8'h00; #1;
        chk1("R5 lock after pin", sr_accept, 1'b0);
        sr_wr = 1'b0;
        wprot_n = 1'b1;
        sr_wr = 1'b1; #1;
        chk1("R5 exit by pin", sr_accept, 1'b1);
        tick(); sr_wr = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R5 cleared", sr_dout, 8'h00);

        // R12 stray done
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R12 idle done ignored", sr_dout, 8'h02);

        // R9 array cycle
        arr_addr = 15'h7FFF; arr_start = 1'b1; #1;
        chk1("R9 allowed", arr_allow, 1'b1);
        tick(); arr_start = 1'b0;
        chk8("R9 busy", sr_dout, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R9 end clears latch", sr_dout, 8'h00);
        write_sr(8'h0C);
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        arr_addr = 15'h0000; arr_start = 1'b1; #1;
        chk1("R9 blocked", arr_allow, 1'b0);
        tick(); arr_start = 1'b0;
        chk8("R9 blocked start ignored", sr_dout, 8'h0E);

        // R11 simultaneous requests
        wen_clr = 1'b1; tick(); wen_clr = 1'b0;
        write_sr(8'h00);
        wen_set = 1'b1; tick(); wen_set = 1'b0;
        sr_wr = 1'b1; sr_din = 8'h04; arr_start = 1'b1; arr_addr = '0; #1;
        chk1("R11 status accepted", sr_accept, 1'b1);
        tick(); sr_wr = 1'b0; arr_start = 1'b0;
        chk8("R11 busy", sr_dout, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        chk8("R11 status write performed", sr_dout, 8'h04);

        finish_run();
    end

endmodule